// File: doc/BRIEF.md
# Serial EEPROM Byte-Write Controller

This block is an I2C master that stores a single byte in a serial EEPROM. After the host raises a one-cycle start command, the block latches the memory address and the data byte and opens a transfer. It sends the write control byte, then the address, then the data. Once the data is acknowledged it closes the transfer with a stop. From that point the EEPROM is busy with its internal programming cycle and ignores the bus.

The block then polls the EEPROM to learn when that cycle is over. Each poll is a start condition followed by the write control byte. A NACK means the EEPROM is still busy, so the block issues a repeated start and polls again. An ACK means programming has finished, and the block ends with a start condition followed directly by a stop, which puts the EEPROM into standby.

A missing acknowledge on any of the three write bytes aborts the operation. The operation also aborts if polling goes on longer than a configured window, 30 ms by default, counted from the first poll start. On an abort the block releases the bus with a stop and raises a sticky error flag. Both lines are open-drain: an output-enable bit of 1 pulls the line low, and SDA is read back through a separate input.

Top module: `eebw_master`

## Requirements
- R1: The first byte after the opening start is the control byte 0xA0 (device code 1010, select bits 000, direction bit 0), sent most significant bit first, with SDA released on the ninth clock for the acknowledge.
- R2: The address byte and then the data byte follow the control byte, each MSB first, and each is sent only after the byte before it was acknowledged (SDA low while SCL is high on the ninth clock).
- R3: A NACK (SDA high on the ninth clock) to the control, address or data byte stops the operation. No later byte is sent, a stop is issued, err_o is set, and no polling takes place.
- R4: After the data byte is acknowledged, the block issues a stop before it starts polling.
- R5: Each poll is a start condition followed by the control byte 0xA0. A NACK to a poll leads to another poll.
- R6: An acknowledged poll is followed by a start condition and then directly by a stop, with no byte between them. The operation then completes with err_o low.
- R7: If no poll has been acknowledged when the timeout window (TOUT_US microseconds from the first poll start) has run out, the block aborts at the end of the poll in progress. It issues a stop and sets err_o.
- R8: busy_o rises in the cycle after an accepted start_i and stays high until the operation ends. A start_i while busy is ignored and does not change the bytes sent.
- R9: done_o is high for exactly one cycle at the end of every operation, whether it succeeded or aborted. err_o holds its value until the next accepted start_i, which clears it.
- R10: Out of reset, and whenever busy_o is low, both line enables are low, and busy_o, done_o and err_o are low.
- R11: Start and stop conditions appear only where the protocol needs them. A successful write shows 2 + P starts and 2 stops, where P is the number of polls. A write aborted on a write byte shows one start and one stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle command to begin a byte write |
| mem_addr_i | input | 8 | EEPROM memory address, latched on start |
| wr_data_i | input | 8 | Data byte, latched on start |
| sda_i | input | 1 | Level sensed on the SDA line |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | Sticky abort flag (missing ACK or poll timeout) |

## Verification
The bench exercises the block against a model EEPROM driven by seeded random addresses and data bytes. Each random case also gets a random number of busy polls before the ACK, and some cases get a NACK placed on one of the three write bytes. Directed cases add address and data values of all ones and all zeros, a zero-wait poll and a poll sequence that never ends. A clean write with several polls shows that the poll loop repeats, and that it stops on the first ACK. A NACK on each write byte in turn shows how far the block gets before it aborts. The endless poll distinguishes the timeout path from a plain NACK abort. A start pulse injected in the middle of an operation, and a clean write that follows a failed one, show that commands are ignored while busy and that the error flag is cleared.

// File: rtl/eebw_pkg.sv
package eebw_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WSTART,
    S_WCTRL,
    S_WADDR,
    S_WDATA,
    S_WSTOP,
    S_PSTART,
    S_PCTRL,
    S_FSTART,
    S_FSTOP
  } seq_e;

  localparam logic [7:0] CTRL_WR = 8'hA0;
  localparam logic [3:0] ACK_BIT = 4'd8;

  function automatic logic is_byte_state(seq_e s);
    return (s == S_WCTRL) || (s == S_WADDR) || (s == S_WDATA) || (s == S_PCTRL);
  endfunction

endpackage

// File: rtl/eebw_qtick.sv
module eebw_qtick #(
  parameter int QCYC = 31
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int QW = (QCYC > 2) ? $clog2(QCYC) : 1;

  logic [QW-1:0] cnt;

  assign tick = run && (cnt == QW'(QCYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eebw_polltimer.sv
module eebw_polltimer #(
  parameter int LIMIT = 1500000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (run && !expired) begin
      if (cnt == TW'(LIMIT - 1)) expired <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end

  // R7: once the window has run out it stays so until the next command
  a_r7_expired_sticky: assert property (@(posedge clk) disable iff (rst)
    (expired && !clr) |=> expired);
endmodule

// File: rtl/eebw_master.sv
module eebw_master
  import eebw_pkg::*;
#(
  parameter int CLK_HZ  = 50000000,
  parameter int SCL_HZ  = 400000,
  parameter int TOUT_US = 30000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [7:0] mem_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  localparam int QCYC     = CLK_HZ / (4 * SCL_HZ);
  localparam int TOUT_CYC = (CLK_HZ / 1000000) * TOUT_US;

  seq_e       st;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] addr_q, data_q;
  logic       ack_q, abort_q, poll_run;
  logic       tick, tout_exp, accept;
  logic [7:0] cur_byte;
  logic       bit_val;
  logic       scl_nx, sda_nx;

  assign accept = (st == S_IDLE) && start_i;

  eebw_qtick #(.QCYC(QCYC)) u_qtick (
    .clk(clk), .rst(rst), .run(st != S_IDLE), .tick(tick)
  );

  eebw_polltimer #(.LIMIT(TOUT_CYC)) u_ptimer (
    .clk(clk), .rst(rst), .clr(accept), .run(poll_run), .expired(tout_exp)
  );

  always_comb begin
    case (st)
      S_WADDR: cur_byte = addr_q;
      S_WDATA: cur_byte = data_q;
      default: cur_byte = CTRL_WR;
    endcase
    bit_val = cur_byte[3'd7 - bitn[2:0]];
  end

  // Quarter-bit line shaping: SCL low in q0/q1, high in q2/q3.
  always_comb begin
    scl_nx = 1'b0;
    sda_nx = sda_oe_o;
    case (st)
      S_IDLE: sda_nx = 1'b0;
      S_WSTART, S_PSTART, S_FSTART: begin
        scl_nx = (q < 2'd2);
        if (q == 2'd1 || q == 2'd2) sda_nx = 1'b0;
        else if (q == 2'd3)         sda_nx = 1'b1;
      end
      S_WSTOP, S_FSTOP: begin
        scl_nx = (q < 2'd2);
        if (q == 2'd3)      sda_nx = 1'b0;
        else if (q != 2'd0) sda_nx = 1'b1;
      end
      default: begin
        scl_nx = (q < 2'd2);
        if (q != 2'd0) sda_nx = (bitn == ACK_BIT) ? 1'b0 : ~bit_val;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      q        <= '0;
      bitn     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      ack_q    <= 1'b0;
      abort_q  <= 1'b0;
      poll_run <= 1'b0;
      scl_oe_o <= 1'b0;
      sda_oe_o <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      scl_oe_o <= scl_nx;
      sda_oe_o <= sda_nx;
      if (st == S_IDLE) begin
        if (start_i) begin
          addr_q   <= mem_addr_i;
          data_q   <= wr_data_i;
          err_o    <= 1'b0;
          abort_q  <= 1'b0;
          poll_run <= 1'b0;
          busy_o   <= 1'b1;
          q        <= '0;
          bitn     <= '0;
          st       <= S_WSTART;
        end
      end else if (tick) begin
        q <= q + 2'd1;
        if (is_byte_state(st) && bitn == ACK_BIT && q == 2'd2) ack_q <= ~sda_i;
        if (q == 2'd3) begin
          case (st)
            S_WSTART: st <= S_WCTRL;
            S_PSTART: st <= S_PCTRL;
            S_FSTART: st <= S_FSTOP;
            S_WCTRL, S_WADDR, S_WDATA, S_PCTRL: begin
              if (bitn != ACK_BIT) begin
                bitn <= bitn + 4'd1;
              end else begin
                bitn <= '0;
                if (ack_q) begin
                  case (st)
                    S_WCTRL: st <= S_WADDR;
                    S_WADDR: st <= S_WDATA;
                    S_WDATA: st <= S_WSTOP;
                    default: st <= S_FSTART;
                  endcase
                end else if (st == S_PCTRL && !tout_exp) begin
                  st <= S_PSTART;
                end else begin
                  err_o   <= 1'b1;
                  abort_q <= 1'b1;
                  st      <= S_WSTOP;
                end
              end
            end
            S_WSTOP: begin
              if (abort_q) begin
                st       <= S_IDLE;
                busy_o   <= 1'b0;
                done_o   <= 1'b1;
                poll_run <= 1'b0;
              end else begin
                st       <= S_PSTART;
                poll_run <= 1'b1;
              end
            end
            default: begin
              st       <= S_IDLE;
              busy_o   <= 1'b0;
              done_o   <= 1'b1;
              poll_run <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  // R9: completion strobe lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8: an accepted command makes the block busy
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
  // R8 / R9: busy only ends together with the done strobe
  a_r8_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
  // R10: lines released whenever idle
  a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!scl_oe_o && !sda_oe_o));
  // R3 / R7: error only raised during an operation
  a_r3_err_in_op: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> busy_o);
endmodule

// File: tb/eebw_master_tb.sv
module eebw_master_tb;
  localparam int CLK_HZ  = 50000000;
  localparam int SCL_HZ  = 1000000;
  localparam int TOUT_US = 100;
  localparam int QCYC    = CLK_HZ / (4 * SCL_HZ);
  localparam int POLL_CYC = 40 * QCYC;
  localparam int TOUT_CYC = (CLK_HZ / 1000000) * TOUT_US;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [7:0] mem_addr_i = '0, wr_data_i = '0;
  logic scl_oe_o, sda_oe_o, busy_o, done_o, err_o;
  logic sl_drv = 1'b0;
  logic scl_w, sda_w;

  assign scl_w = ~scl_oe_o;
  assign sda_w = ~(sda_oe_o | sl_drv);

  always #10 clk = ~clk;

  eebw_master #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .TOUT_US(TOUT_US)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .mem_addr_i(mem_addr_i),
    .wr_data_i(wr_data_i), .sda_i(sda_w), .scl_oe_o(scl_oe_o),
    .sda_oe_o(sda_oe_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  int nt = 0, nf = 0;

  // EEPROM model configuration and log
  logic clr_log = 1'b0;
  int   cfg_nack_at = 7;
  int   cfg_busy_polls = 0;
  int   starts, stops, polls, idx, bitc, nbytes, since_start;
  logic in_x, wr_done, ss_seen, ps, pd;
  logic [7:0] sh;
  logic [7:0] wb [3];

  always @(posedge clk) begin
    if (clr_log) begin
      starts = 0; stops = 0; polls = 0; idx = 0; bitc = 0; nbytes = 0;
      since_start = 0; in_x = 0; wr_done = 0; ss_seen = 0; sl_drv <= 1'b0;
      wb[0] = 8'h00; wb[1] = 8'h00; wb[2] = 8'h00; sh = 8'h00;
    end else begin
      if (scl_w && ps && pd && !sda_w) begin
        starts++; bitc = 0; idx = 0; in_x = 1; since_start = 0;
      end else if (scl_w && ps && !pd && sda_w) begin
        stops++;
        if (wr_done && since_start == 0) ss_seen = 1;
        wr_done = 1; in_x = 0;
      end else if (scl_w && !ps && in_x) begin
        if (bitc < 8) begin sh = {sh[6:0], sda_w}; bitc++; end
      end else if (!scl_w && ps && in_x) begin
        if (bitc == 8) begin
          bitc = 9; since_start++; nbytes++;
          if (!wr_done) begin
            if (idx < 3) wb[idx] = sh;
            if (idx != cfg_nack_at) sl_drv <= 1'b1;
          end else begin
            if (polls >= cfg_busy_polls) sl_drv <= 1'b1;
            polls++;
          end
        end else if (bitc == 9) begin
          sl_drv <= 1'b0; bitc = 0; idx++;
        end
      end
      ps = scl_w; pd = sda_w;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nt++;
    if (!ok) begin
      nf++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  endtask

  function automatic int exp_timeout_polls();
    return (TOUT_CYC + POLL_CYC - 1) / POLL_CYC;
  endfunction

  // nack_at: 0..2 NACK on that write byte, else none; bp: busy polls
  task automatic run_op(input logic [7:0] a, input logic [7:0] d, input int nack_at,
                        input int bp, input bit tout, input bit poke);
    int dn = 0, cyc = 0;
    bit exp_err;
    cfg_nack_at = nack_at; cfg_busy_polls = bp;
    @(negedge clk) clr_log = 1'b1;
    @(negedge clk) clr_log = 1'b0;
    start_i = 1'b1; mem_addr_i = a; wr_data_i = d;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    chk(err_o == 1'b0, "R9 err cleared by start", err_o, 0);
    if (poke) begin
      repeat (200) @(negedge clk);
      start_i = 1'b1; mem_addr_i = ~a; wr_data_i = ~d;
      @(negedge clk) start_i = 1'b0;
    end
    while (cyc < 40000) begin
      @(negedge clk); cyc++;
      if (done_o) dn++;
      if (!busy_o) break;
    end
    chk(cyc < 40000, "R8 busy ends", cyc, 0);
    repeat (4) begin @(negedge clk); if (done_o) dn++; end
    chk(dn == 1, "R9 done single pulse", dn, 1);
    chk(!scl_oe_o && !sda_oe_o, "R10 lines released after op",
        {scl_oe_o, sda_oe_o}, 0);
    exp_err = (nack_at < 3) || tout;
    chk(err_o == exp_err, "R3/R7 error flag", err_o, exp_err);
    chk(wb[0] == 8'hA0, "R1 control byte", wb[0], 8'hA0);
    if (nack_at < 3) begin
      chk(nbytes == nack_at + 1, "R3 bytes before abort", nbytes, nack_at + 1);
      chk(polls == 0, "R3 no polling after abort", polls, 0);
      chk(starts == 1 && stops == 1, "R11 abort start/stop count",
          starts * 10 + stops, 11);
      if (nack_at >= 1) chk(wb[1] == a, "R2 address byte", wb[1], a);
    end else begin
      chk(wb[1] == a, "R2 address byte", wb[1], a);
      chk(wb[2] == d, "R2 data byte", wb[2], d);
      if (tout) begin
        chk(polls >= exp_timeout_polls() - 1 && polls <= exp_timeout_polls() + 1,
            "R7 poll count at timeout", polls, exp_timeout_polls());
        chk(stops == 2 && !ss_seen, "R7 abort stop, no standby", stops, 2);
      end else begin
        chk(polls == bp + 1, "R5 poll repeats until ACK", polls, bp + 1);
        chk(ss_seen, "R6 start then stop at end", ss_seen, 1);
        chk(stops == 2, "R4 stop after data and final", stops, 2);
        chk(starts == 2 + polls, "R11 start count", starts, 2 + polls);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nf++; nt++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    clr_log = 1'b1;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0; clr_log = 1'b0;
    @(negedge clk);
    chk({scl_oe_o, sda_oe_o, busy_o, done_o, err_o} == 5'b0, "R10 reset state",
        {scl_oe_o, sda_oe_o, busy_o, done_o, err_o}, 0);
    // directed corners
    run_op(8'hFF, 8'h00, 7, 0, 1'b0, 1'b0);
    run_op(8'h00, 8'hFF, 7, 3, 1'b0, 1'b1);  // R8 mid-op start ignored
    run_op(8'h5A, 8'hC3, 0, 0, 1'b0, 1'b0);  // R3 NACK control
    run_op(8'h5A, 8'hC3, 2, 0, 1'b0, 1'b0);  // R3 NACK data
    run_op(8'h12, 8'h34, 7, 100000, 1'b1, 1'b0); // R7 timeout
    run_op(8'h81, 8'h7E, 7, 1, 1'b0, 1'b0);  // R9 err cleared after failure
    for (int i = 0; i < 10; i++) begin
      logic [7:0] ra, rd;
      int rn, rb;
      ra = 8'($urandom); rd = 8'($urandom);
      rn = int'($urandom % 5); rb = int'($urandom % 4);
      if (rn >= 3) rn = 7;
      run_op(ra, rd, rn, rb, 1'b0, 1'b0);
    end
    summary();
  end
endmodule